// File: doc/BRIEF.md
# Receive Character Time-out Counter

This block raises the receive time-out request of a FIFO UART. When characters sit in the receive FIFO and neither a new character arrives nor the host reads the holding register, the host still has to be told that data is waiting. The block counts 16x oversample ticks while the FIFO is not empty. After four character times with no such event, it sets a sticky time-out flag.

The length of one character time comes from the configured frame: one start bit, five to eight data bits, an optional parity bit, and a stop length of one, one and a half or two bits. Because counting is done in oversample ticks, the half-bit stop length is exact. The counter restarts at the centre of every received stop bit and on every holding-register read. The block also produces the receive-data-ready request (FIFO level at or above the trigger). That request shares one enable and one priority level with the time-out, and the two are merged into a single request output.

Top module: `rx_timeout_unit`

## Requirements
- R1: With the FIFO not empty and no restart, `timeout_irq_o` (when enabled) rises after exactly N oversample ticks counted from the last restart, where N = 4 x character ticks. It is low after N-1 ticks.
- R2: Character ticks = 16 (start) + 16 x data bits + 16 if `parity_en_i` + stop ticks. `data_bits_i` 0,1,2,3 selects 5,6,7,8 data bits. `stop_sel_i` 0 gives 16 stop ticks, 1 gives 24, and 2 or 3 give 32.
- R3: A pulse on `stop_mid_i` restarts the count from zero, so the next time-out needs a further N ticks. It does not clear a time-out that is already set.
- R4: A pulse on `rhr_read_i` restarts the count and clears the time-out flag on the next clock.
- R5: While `fifo_empty_i` is high, no ticks are counted and the time-out flag is cleared on the next clock. Counting starts from zero once the FIFO holds data again.
- R6: `rx_data_irq_o` is high exactly when `rx_irq_en_i` is high, `fifo_level_i` is nonzero and `fifo_level_i` >= `rx_trig_i`. It follows these inputs continuously, with no clock delay.
- R7: Once set, the time-out flag stays set through further ticks and stop-bit strobes until a read or an empty FIFO clears it.
- R8: `rx_irq_en_i` only masks the outputs: the count and the flag keep running while it is low. `rx_req_o` is the OR of `timeout_irq_o` and `rx_data_irq_o`.
- R9: After reset all outputs are low and the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick16_i | input | 1 | 16x oversample tick, one cycle wide |
| stop_mid_i | input | 1 | Strobe at the centre of a received stop bit |
| rhr_read_i | input | 1 | Holding-register read strobe |
| fifo_empty_i | input | 1 | Receive FIFO empty |
| fifo_level_i | input | LVL_W | Receive FIFO occupancy |
| rx_trig_i | input | LVL_W | Receive trigger level |
| data_bits_i | input | 2 | Data length code (0..3 = 5..8 bits) |
| parity_en_i | input | 1 | Parity bit present |
| stop_sel_i | input | 2 | Stop length code (0 = 1, 1 = 1.5, 2/3 = 2 bits) |
| rx_irq_en_i | input | 1 | Shared enable for data-ready and time-out |
| timeout_irq_o | output | 1 | Time-out request |
| rx_data_irq_o | output | 1 | Data-ready request |
| rx_req_o | output | 1 | Merged receive request |

## Verification
A wrong internal count shows at the ports as a time-out edge one or more ticks early or late. The bench therefore checks both the tick before the expected edge and the tick on which it is expected, for random frame formats. A missed restart or a missed clear leaves `timeout_irq_o` high or lets it fire early, and this is visible within one clock of the strobe or within one time-out period. Data-ready errors are combinational and are visible at once.

// File: rtl/rto_pkg.sv
package rto_pkg;
  localparam int unsigned OVS   = 16;
  localparam int unsigned CHARS = 4;
  localparam int unsigned DEPTH = 128;

  typedef enum logic [1:0] {
    STOP_ONE  = 2'd0,
    STOP_HALF = 2'd1,
    STOP_TWO  = 2'd2,
    STOP_TWOB = 2'd3
  } stop_len_e;
endpackage

// File: rtl/rto_frame_len.sv
module rto_frame_len
  import rto_pkg::*;
#(
  parameter int unsigned OVS_P   = OVS,
  parameter int unsigned CHARS_P = CHARS,
  parameter int unsigned TW      = 10
) (
  input  logic [1:0]    data_bits_i,
  input  logic          parity_en_i,
  input  stop_len_e     stop_sel_i,
  output logic [TW-1:0] limit_o
);
  localparam int unsigned HALF = OVS_P / 2;

  logic [TW-1:0] halves;
  logic [TW-1:0] stop_h;

  always_comb begin
    unique case (stop_sel_i)
      STOP_ONE:  stop_h = TW'(2);
      STOP_HALF: stop_h = TW'(3);
      default:   stop_h = TW'(4);
    endcase
    // start + 5 base data bits = 6 bits = 12 half-bits
    halves = TW'(12) + TW'({data_bits_i, 1'b0}) + (parity_en_i ? TW'(2) : TW'(0)) + stop_h;
    limit_o = TW'(32'(halves) * HALF * CHARS_P);
  end
endmodule

// File: rtl/rto_counter.sv
module rto_counter #(
  parameter int unsigned TW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          restart_i,
  input  logic          clear_i,
  input  logic          empty_i,
  input  logic [TW-1:0] limit_i,
  output logic          tmo_o
);
  logic [TW-1:0] cnt_q;
  logic          tmo_q;
  logic          reach;

  assign reach = tick_i && !restart_i && !empty_i && ((cnt_q + TW'(1)) >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i || empty_i) begin
      cnt_q <= '0;
    end else if (tick_i && (cnt_q < limit_i)) begin
      cnt_q <= cnt_q + TW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tmo_q <= 1'b0;
    else if (clear_i) tmo_q <= 1'b0;
    else if (reach)   tmo_q <= 1'b1;
  end

  assign tmo_o = tmo_q;

  AST_EMPTY_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_i |=> (!tmo_q && cnt_q == '0)); // R5
  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0)); // R3
  AST_SET_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_q) |-> (($past(cnt_q) + TW'(1)) >= $past(limit_i))); // R1
  AST_TMO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_q && !clear_i) |=> tmo_q); // R7
endmodule

// File: rtl/rto_req.sv
module rto_req #(
  parameter int unsigned LW = 8
) (
  input  logic          en_i,
  input  logic          tmo_i,
  input  logic [LW-1:0] level_i,
  input  logic [LW-1:0] trig_i,
  output logic          tmo_irq_o,
  output logic          dr_irq_o,
  output logic          req_o
);
  logic at_trig;

  assign at_trig   = (level_i != '0) && (level_i >= trig_i);
  assign tmo_irq_o = en_i && tmo_i;
  assign dr_irq_o  = en_i && at_trig;
  assign req_o     = tmo_irq_o || dr_irq_o;

  always_comb begin
    AST_REQ_MASKED: assert (en_i || !req_o); // R8
  end
endmodule

// File: rtl/rx_timeout_unit.sv
module rx_timeout_unit
  import rto_pkg::*;
#(
  parameter int unsigned OVS_P   = OVS,
  parameter int unsigned CHARS_P = CHARS,
  parameter int unsigned DEPTH_P = DEPTH,
  localparam int unsigned LVL_W  = $clog2(DEPTH_P + 1),
  localparam int unsigned TW     = $clog2(CHARS_P * OVS_P * 12 + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick16_i,
  input  logic             stop_mid_i,
  input  logic             rhr_read_i,
  input  logic             fifo_empty_i,
  input  logic [LVL_W-1:0] fifo_level_i,
  input  logic [LVL_W-1:0] rx_trig_i,
  input  logic [1:0]       data_bits_i,
  input  logic             parity_en_i,
  input  logic [1:0]       stop_sel_i,
  input  logic             rx_irq_en_i,
  output logic             timeout_irq_o,
  output logic             rx_data_irq_o,
  output logic             rx_req_o
);
  logic [TW-1:0] limit;
  logic          tmo;

  rto_frame_len #(.OVS_P(OVS_P), .CHARS_P(CHARS_P), .TW(TW)) u_len (
    .data_bits_i (data_bits_i),
    .parity_en_i (parity_en_i),
    .stop_sel_i  (stop_len_e'(stop_sel_i)),
    .limit_o     (limit)
  );

  rto_counter #(.TW(TW)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick16_i),
    .restart_i (stop_mid_i || rhr_read_i),
    .clear_i   (rhr_read_i || fifo_empty_i),
    .empty_i   (fifo_empty_i),
    .limit_i   (limit),
    .tmo_o     (tmo)
  );

  rto_req #(.LW(LVL_W)) u_req (
    .en_i      (rx_irq_en_i),
    .tmo_i     (tmo),
    .level_i   (fifo_level_i),
    .trig_i    (rx_trig_i),
    .tmo_irq_o (timeout_irq_o),
    .dr_irq_o  (rx_data_irq_o),
    .req_o     (rx_req_o)
  );

  AST_READ_DROPS_TMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rhr_read_i |=> !timeout_irq_o); // R4
endmodule

// File: tb/rx_timeout_unit_tb.sv
module rx_timeout_unit_tb;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, stopm = 0, rd = 0, empty = 1, en = 1, par = 0;
  logic [LW-1:0] lvl = '0, trig = 8'd1;
  logic [1:0] db = 0, ss = 0;
  logic to_o, dr_o, rq_o;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rx_timeout_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .stop_mid_i(stopm),
    .rhr_read_i(rd), .fifo_empty_i(empty), .fifo_level_i(lvl), .rx_trig_i(trig),
    .data_bits_i(db), .parity_en_i(par), .stop_sel_i(ss), .rx_irq_en_i(en),
    .timeout_irq_o(to_o), .rx_data_irq_o(dr_o), .rx_req_o(rq_o)
  );

  function automatic int exp_limit(logic [1:0] d, logic p, logic [1:0] s);
    int st = (s == 2'd0) ? 16 : (s == 2'd1) ? 24 : 32;
    return 4 * (16 + 16 * (5 + d) + (p ? 16 : 0) + st);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
    end
  endtask

  task automatic pulse_rd();
    @(negedge clk) rd = 1;
    @(negedge clk) rd = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stopm = 1;
    @(negedge clk) stopm = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int n, k;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk("R9 reset timeout", to_o, 0);
    chk("R9 reset req", rq_o, 0);
    rst_n = 1;
    @(negedge clk);

    // R5: empty FIFO never times out
    ticks(exp_limit(0, 0, 0) + 5);
    chk("R5 empty no timeout", to_o, 0);

    // R1 R2: random frames, exact edge
    for (int it = 0; it < 10; it++) begin
      db = 2'($urandom); par = 1'($urandom); ss = 2'($urandom);
      if (it == 0) begin db = 0; par = 0; ss = 1; end
      if (it == 1) begin db = 3; par = 1; ss = 3; end
      n = exp_limit(db, par, ss);
      empty = 0;
      pulse_rd();
      ticks(n - 1);
      chk("R2 no timeout at N-1", to_o, 0);
      ticks(1);
      chk("R1 timeout at N", to_o, 1);
      chk("R8 req follows timeout", rq_o, 1);
      ticks(5); pulse_stop();
      chk("R7 timeout sticky", to_o, 1);
      pulse_rd();
      chk("R4 read clears", to_o, 0);
      // R3: stop-bit centre restarts
      k = 1 + int'($urandom % (n - 2));
      ticks(k);
      pulse_stop();
      ticks(n - 1);
      chk("R3 restart at stop centre", to_o, 0);
      ticks(1);
      chk("R3 timeout after restart", to_o, 1);
      @(negedge clk) empty = 1;
      @(negedge clk);
      chk("R5 empty clears", to_o, 0);
    end

    // R8: enable masks output only
    db = 1; par = 0; ss = 0; n = exp_limit(db, par, ss);
    en = 0; empty = 0;
    pulse_rd();
    ticks(n);
    chk("R8 masked timeout", to_o, 0);
    @(negedge clk) en = 1;
    #1 chk("R8 flag kept while masked", to_o, 1);
    pulse_rd();

    // R6: data-ready, random and corners
    for (int it = 0; it < 20; it++) begin
      lvl = LW'($urandom % 129); trig = LW'(1 + $urandom % 128);
      en = 1'($urandom);
      if (it == 0) begin lvl = 8'd16; trig = 8'd16; en = 1; end
      if (it == 1) begin lvl = 8'd15; trig = 8'd16; en = 1; end
      if (it == 2) begin lvl = 8'd0;  trig = 8'd0;  en = 1; end
      #1;
      chk("R6 data ready", dr_o, int'(en && lvl != 0 && lvl >= trig));
      chk("R8 merged req", rq_o, int'(dr_o || to_o));
      @(negedge clk);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule